// File: doc/BRIEF.md
# Time-Gated Pulse Accumulator

The block sums a stream of binary pulse images into one integer image, one counter per pixel, but only for iterations that an iteration-count schedule lets through. Each iteration begins with a frame strobe. The schedule keeps the gate shut for a programmable number of leading iterations. After that it alternates between an open window and a shut window, each with its own programmable length. A background that pulses with a fixed period can then be left out of the sum by setting the windows to match that period.

Pulse bits arrive as words of `LANES` pixels. Each word carries its word address, so pixel `w*LANES + l` is lane `l` of word `w`. The strobe may share a cycle with the first word of its frame. The gate state is taken at the strobe and holds for the whole frame. A clear input zeroes every counter and returns the schedule to the start of the leading shut period. A registered read port returns one pixel's count.

Top module: `pulse_gate_accum`

## Requirements
- R1: After reset every pixel count reads 0 and `gate_o` is 0.
- R2: The first `start_len_i` frames after reset or clear are shut: `gate_o` is 0 and no pixel count changes.
- R3: After the leading period, with both window lengths nonzero, the gate is open for `open_len_i` consecutive frames.
- R4: The open window is followed by `close_len_i` shut frames, and the two windows alternate without end. For frame index n counted from 0, with m = n - `start_len_i`, the frame is open exactly when (m mod (open+close)) < open.
- R5: In an open frame, every word beat with `beat_valid_i` high adds `beat_bits_i[l]` to pixel `beat_addr_i*LANES + l`. The frame's strobe cycle is included in this.
- R6: Counts are unsigned, `ACC_W` bits wide, and stop at 2^ACC_W-1 instead of wrapping.
- R7: If `open_len_i` is 0, the gate never opens. This also holds when `close_len_i` is 0.
- R8: If `close_len_i` is 0 and `open_len_i` is nonzero, every frame after the leading period is open.
- R9: `clear_i` zeroes all counts and the schedule, and forces `gate_o` to 0. It takes priority over a strobe or beat in the same cycle, and that frame is neither counted nor accumulated.
- R10: `rd_data_o` shows the count of pixel `rd_addr_i` one clock after the address is presented.
- R11: `gate_o` changes only on the cycle after a strobe or clear. Length inputs changed in the middle of a frame do not alter that frame's gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Zero counts and restart the schedule |
| start_len_i | input | CNT_W | Leading shut frames |
| open_len_i | input | CNT_W | Open window length in frames |
| close_len_i | input | CNT_W | Shut window length in frames |
| frame_strobe_i | input | 1 | Start of a new iteration |
| beat_valid_i | input | 1 | Pulse word present |
| beat_addr_i | input | WADDR_W | Word index of the pulse word |
| beat_bits_i | input | LANES | Pulse bits, one per pixel lane |
| rd_addr_i | input | PADDR_W | Pixel to read |
| rd_data_o | output | ACC_W | Count of the addressed pixel, registered |
| gate_o | output | 1 | Gate state of the current frame |

## Verification
`gate_o` takes its new value on the edge that samples the strobe. The bench therefore reads it at the falling edge after that edge, and again at the end of the frame, after the length inputs have been disturbed and restored. Counts are updated on the edge that takes each beat. Reads come back one edge after the address. The read sweep moves the address every cycle and expects the value for the previous address, so a combinational or two-stage read path fails the check. Inputs change 1 ns after a rising edge and are sampled at the falling edge. Every (start, open, close) combination from 0 to 3 is run for 20 frames against an arithmetic model, and some runs include a clear that arrives together with a strobe.

// File: rtl/pga_pkg.sv
package pga_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_OPEN  = 2'd1,
    PH_SHUT  = 2'd2
  } phase_e;
endpackage

// File: rtl/pga_sched.sv
module pga_sched
  import pga_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] start_len_i,
  input  logic [CNT_W-1:0] open_len_i,
  input  logic [CNT_W-1:0] close_len_i,
  output logic             gate_now_o,
  output logic             gate_o
);
  phase_e           phase_q, ph;
  logic [CNT_W-1:0] cnt_q, ct;
  logic             gate_q;

  // Resolve exhausted phases; zero-length windows fall through.
  always_comb begin
    ph = phase_q;
    ct = cnt_q;
    if (ph == PH_START && ct >= start_len_i) begin
      ph = PH_OPEN;
      ct = '0;
    end
    if (ph == PH_OPEN && ct >= open_len_i) begin
      ph = PH_SHUT;
      ct = '0;
    end
    if (ph == PH_SHUT && ct >= close_len_i) begin
      if (open_len_i != '0) ph = PH_OPEN;
      ct = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_START;
      cnt_q   <= '0;
      gate_q  <= 1'b0;
    end else if (clear_i) begin
      phase_q <= PH_START;
      cnt_q   <= '0;
      gate_q  <= 1'b0;
    end else if (strobe_i) begin
      phase_q <= ph;
      cnt_q   <= ct + 1'b1;
      gate_q  <= (ph == PH_OPEN);
    end
  end

  assign gate_now_o = clear_i ? 1'b0 : (strobe_i ? (ph == PH_OPEN) : gate_q);
  assign gate_o     = gate_q;

  // R11
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !clear_i) |=> $stable(gate_o));

  // R9
  clear_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!gate_o && phase_q == PH_START && cnt_q == '0));

  // R7
  no_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !clear_i && open_len_i == '0) |=> !gate_o);

  // R8
  always_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !clear_i && close_len_i == '0 && open_len_i != '0 &&
     phase_q != PH_START) |=> gate_o);

  // R2
  start_shut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !clear_i && phase_q == PH_START && cnt_q < start_len_i) |=> !gate_o);
endmodule

// File: rtl/pga_cell.sv
module pga_cell #(
  parameter int ACC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam logic [ACC_W-1:0] MAX = '1;

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        acc_q <= '0;
    else if (clr_i)                     acc_q <= '0;
    else if (inc_i && acc_q != MAX)     acc_q <= acc_q + 1'b1;
  end

  assign acc_o = acc_q;

  // R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == MAX && !clr_i) |=> acc_q == MAX);

  // R5
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && acc_q != MAX) |=> acc_q == $past(acc_q) + 1'b1);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(acc_q));

  // R9
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);
endmodule

// File: rtl/pga_array.sv
module pga_array #(
  parameter int NPIX    = 64,
  parameter int LANES   = 8,
  parameter int ACC_W   = 8,
  parameter int WADDR_W = 3,
  parameter int PADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [WADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]   bits_i,
  input  logic [PADDR_W-1:0] rd_addr_i,
  output logic [ACC_W-1:0]   rd_data_o
);
  localparam int WORDS = NPIX / LANES;

  logic [ACC_W-1:0] acc_w [NPIX];
  logic [ACC_W-1:0] rd_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = en_i && (addr_i == WADDR_W'(w));
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      pga_cell #(.ACC_W(ACC_W)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .inc_i  (hit && bits_i[l]),
        .acc_o  (acc_w[w*LANES + l])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if ({1'b0, rd_addr_i} < (PADDR_W+1)'(NPIX)) rd_q <= acc_w[rd_addr_i];
    else rd_q <= '0;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/pulse_gate_accum.sv
module pulse_gate_accum #(
  parameter int NPIX  = 64,
  parameter int LANES = 8,
  parameter int ACC_W = 8,
  parameter int CNT_W = 8,
  localparam int WORDS   = NPIX / LANES,
  localparam int WADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int PADDR_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [CNT_W-1:0]   start_len_i,
  input  logic [CNT_W-1:0]   open_len_i,
  input  logic [CNT_W-1:0]   close_len_i,
  input  logic               frame_strobe_i,
  input  logic               beat_valid_i,
  input  logic [WADDR_W-1:0] beat_addr_i,
  input  logic [LANES-1:0]   beat_bits_i,
  input  logic [PADDR_W-1:0] rd_addr_i,
  output logic [ACC_W-1:0]   rd_data_o,
  output logic               gate_o
);
  logic gate_now;

  pga_sched #(.CNT_W(CNT_W)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .strobe_i    (frame_strobe_i),
    .start_len_i (start_len_i),
    .open_len_i  (open_len_i),
    .close_len_i (close_len_i),
    .gate_now_o  (gate_now),
    .gate_o      (gate_o)
  );

  pga_array #(
    .NPIX    (NPIX),
    .LANES   (LANES),
    .ACC_W   (ACC_W),
    .WADDR_W (WADDR_W),
    .PADDR_W (PADDR_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clear_i),
    .en_i      (gate_now && beat_valid_i),
    .addr_i    (beat_addr_i),
    .bits_i    (beat_bits_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  // R1
  reset_shut_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !gate_o);
endmodule

// File: tb/pulse_gate_accum_bench.sv
module pulse_gate_accum_bench;
  localparam int NP = 16;
  localparam int LN = 4;
  localparam int WD = NP / LN;
  localparam int MAXV = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic [3:0] s_len = '0, o_len = '0, c_len = '0;
  logic       strobe = 1'b0, valid = 1'b0;
  logic [1:0] baddr = '0;
  logic [3:0] bbits = '0;
  logic [3:0] raddr = '0;
  logic [2:0] rdata;
  logic       gate;

  int checks = 0, errs = 0;
  int model [NP];
  int n_frame = 0;
  int S = 0, O = 0, C = 0;

  always #2 clk = ~clk;

  pulse_gate_accum #(.NPIX(NP), .LANES(LN), .ACC_W(3), .CNT_W(4)) u_pulse_gate_accum (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .start_len_i(s_len), .open_len_i(o_len), .close_len_i(c_len),
    .frame_strobe_i(strobe), .beat_valid_i(valid), .beat_addr_i(baddr),
    .beat_bits_i(bbits), .rd_addr_i(raddr), .rd_data_o(rdata), .gate_o(gate)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_gate(int n, int s, int o, int c);
    if (n < s) return 1'b0;
    if (o == 0) return 1'b0;
    if (c == 0) return 1'b1;
    return ((n - s) % (o + c)) < o;
  endfunction

  function automatic string gate_req(int n, int s, int o, int c);
    if (n < s) return "R2";
    if (o == 0) return "R7";
    if (c == 0) return "R8";
    if (((n - s) % (o + c)) < o) return "R3";
    return "R4";
  endfunction

  function automatic logic [3:0] pat(int f, int w, int tag);
    if ((f + tag) % 5 == 0) return 4'hF;
    return 4'(f * 7 + w * 3 + tag);
  endfunction

  task automatic read_all(string req);
    @(posedge clk); #1 raddr = 4'd0;
    for (int p = 0; p < NP; p++) begin
      @(posedge clk); #1 raddr = 4'(p + 1);
      @(negedge clk);
      // R10: value of previous address, one edge after it was presented
      chk(model[p] == MAXV ? "R6 R10" : req, int'(rdata), model[p]);
    end
  endtask

  task automatic do_frame(int f, int tag, bit with_clear);
    bit    g;
    string rq;
    if (with_clear) begin
      for (int p = 0; p < NP; p++) model[p] = 0;
      n_frame = 0;
      g = 1'b0;
      rq = "R9";
    end else begin
      g = exp_gate(n_frame, S, O, C);
      rq = gate_req(n_frame, S, O, C);
      if (g)
        for (int w = 0; w < WD; w++)
          for (int l = 0; l < LN; l++)
            if (pat(f, w, tag)[l] && model[w*LN+l] < MAXV) model[w*LN+l]++;
      n_frame++;
    end
    @(posedge clk); #1;
    strobe = 1'b1; clear = with_clear; valid = 1'b1; baddr = 2'd0; bbits = pat(f, 0, tag);
    for (int w = 1; w < WD; w++) begin
      @(posedge clk); #1;
      strobe = 1'b0; clear = 1'b0; baddr = 2'(w); bbits = pat(f, w, tag);
      if (w == 1) begin
        // disturb lengths mid-frame (R11)
        s_len = 4'd15; o_len = 4'd0; c_len = 4'd0;
        @(negedge clk);
        chk(rq, int'(gate), int'(g));
      end
    end
    @(posedge clk); #1;
    valid = 1'b0;
    s_len = 4'(S); o_len = 4'(O); c_len = 4'(C);
    @(negedge clk);
    chk("R11", int'(gate), int'(g));
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) model[p] = 0;
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", int'(gate), 0);
    read_all("R1");

    for (int cfg = 0; cfg < 64; cfg++) begin
      S = cfg % 4; O = (cfg / 4) % 4; C = cfg / 16;
      s_len = 4'(S); o_len = 4'(O); c_len = 4'(C);
      @(posedge clk); #1 clear = 1'b1;
      @(posedge clk); #1 clear = 1'b0;
      for (int p = 0; p < NP; p++) model[p] = 0;
      n_frame = 0;
      @(negedge clk);
      chk("R9", int'(gate), 0);
      for (int f = 0; f < 20; f++)
        do_frame(f, cfg, (cfg % 7 == 3) && (f == 10));
      read_all("R5 R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule